// File: doc/BRIEF.md
# Configurable Pad I/O Cell

A single pad-side I/O cell that sits between the routing fabric and a modelled pad. Static configuration inputs pick how the cell behaves. As an input it can pass the pad straight through, capture it in a flop on the rising I/O clock, or hold it in a level-sensitive latch. As a driver it can drive only, or drive and receive as a bidirectional pin with three-state control. The pad is modelled as three wires: a drive value, a drive enable and the sensed pad level.

The driver's enable comes from one of four sources picked by a 2-bit selector: a constant on, either of two chip-wide output enables, or a locally generated product-term enable. A further bit switches the driver between push-pull and open-drain behaviour. An all-zero configuration, which is the erased state, gives a pass-through input with push-pull drive. An active-low asynchronous reset clears the input storage.

Top module: `pio_cell`

## Requirements
- R1: While rst_ni is low, din_o reads 0 in registered-input mode (mode_i=1) and latched-input mode (mode_i=2). Reset takes effect without a clock edge.
- R2: In pass-through input mode (mode_i=0), and in the unused codes 5 to 7, din_o follows pad_i combinationally.
- R3: In registered-input mode (mode_i=1), din_o takes the value pad_i had at the last rising edge of clk_io_i. A pad change after that edge is not visible until the next rising edge.
- R4: In latched-input mode (mode_i=2), the latch is transparent while clk_io_i is high and holds while it is low. din_o shows the last pad value seen before clk_io_i fell.
- R5: In every mode other than 3 and 4, pad_oe_o stays 0 whatever oe_sel_i, goe0_i, goe1_i, oe_pt_i and dout_i are.
- R6: The enable source is set by oe_sel_i: 0 gives always on, 1 gives goe0_i, 2 gives goe1_i and 3 gives oe_pt_i.
- R7: With od_en_i=0 (push-pull, the erased default), pad_o equals dout_i in every mode, and in modes 3 and 4 pad_oe_o equals the selected enable.
- R8: With od_en_i=1 (open-drain), pad_o is 0 in every mode. In modes 3 and 4, pad_oe_o is 1 only when the selected enable is 1 and dout_i is 0.
- R9: In drive-only mode (mode_i=3), din_o returns dout_i and ignores pad_i.
- R10: In bidirectional mode (mode_i=4), din_o follows pad_i combinationally while the driver follows R6 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io_i | input | 1 | I/O clock for the input flop and latch |
| rst_ni | input | 1 | Active-low asynchronous reset of the input storage |
| mode_i | input | 3 | Cell mode: 0 pass-through, 1 flop, 2 latch, 3 drive-only, 4 bidirectional |
| oe_sel_i | input | 2 | Enable source: 0 on, 1 goe0_i, 2 goe1_i, 3 oe_pt_i |
| od_en_i | input | 1 | 1 selects open-drain drive, 0 push-pull |
| dout_i | input | 1 | Data from the fabric to drive out |
| oe_pt_i | input | 1 | Local product-term output enable |
| goe0_i | input | 1 | Chip-wide output enable 0 |
| goe1_i | input | 1 | Chip-wide output enable 1 |
| pad_i | input | 1 | Sensed pad level |
| pad_o | output | 1 | Pad drive value |
| pad_oe_o | output | 1 | Pad drive enable |
| din_o | output | 1 | Input value returned to the fabric |

## Verification
A corrupted flop or latch shows at din_o only one I/O-clock phase after the bad capture, so the checks sample in the low phase right after each edge. Pad changes are placed both before and after the rising edge, which separates edge capture from level capture. A wrong enable decode or a wrong drive-type rule shows at pad_oe_o and pad_o in the same cycle, so each enable source is switched on and off on its own with the others held at the opposite level. Input-only modes are checked with every enable asserted, to show the driver stays off.

// File: rtl/pio_cell_pkg.sv
`timescale 1ns/1ps
package pio_cell_pkg;
  typedef enum logic [2:0] {
    PIO_IN_COMB = 3'd0,
    PIO_IN_REG  = 3'd1,
    PIO_IN_LAT  = 3'd2,
    PIO_OUT     = 3'd3,
    PIO_BIDIR   = 3'd4
  } pio_mode_e;

  typedef enum logic [1:0] {
    OES_ON = 2'd0,
    OES_G0 = 2'd1,
    OES_G1 = 2'd2,
    OES_PT = 2'd3
  } pio_oesel_e;

  localparam int unsigned NUM_GOE = 2;

  function automatic logic drives_pad(logic [2:0] m);
    return (m == PIO_OUT) || (m == PIO_BIDIR);
  endfunction
endpackage

// File: rtl/pio_in_path.sv
`timescale 1ns/1ps
module pio_in_path
  import pio_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk_io_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       pad_i,
  input  logic       dout_i,
  output logic       din_o
);
  logic reg_q;
  logic lat_q;

  always_ff @(posedge clk_io_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= RST_VAL;
    else         reg_q <= pad_i;
  end

  // transparent while clock high
  always_latch begin
    if (!rst_ni)       lat_q <= RST_VAL;
    else if (clk_io_i) lat_q <= pad_i;
  end

  always_comb begin
    unique case (mode_i)
      PIO_IN_REG: din_o = reg_q;
      PIO_IN_LAT: din_o = lat_q;
      PIO_OUT:    din_o = dout_i;
      default:    din_o = pad_i;
    endcase
  end

  // R3
  reg_capture_chk: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_i == PIO_IN_REG && $past(mode_i) == PIO_IN_REG)
      |-> din_o == $past(pad_i));

  // R4
  lat_follow_chk: assert property (@(negedge clk_io_i) disable iff (!rst_ni)
    (mode_i == PIO_IN_LAT) |-> din_o == pad_i);
endmodule

// File: rtl/pio_out_drv.sv
`timescale 1ns/1ps
module pio_out_drv
  import pio_cell_pkg::*;
(
  input  logic               clk_io_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         oe_sel_i,
  input  logic               od_en_i,
  input  logic               dout_i,
  input  logic               oe_pt_i,
  input  logic [NUM_GOE-1:0] goe_i,
  output logic               pad_o,
  output logic               pad_oe_o
);
  logic oe_sel_val;
  logic drv_mode;

  always_comb begin
    unique case (oe_sel_i)
      OES_ON:  oe_sel_val = 1'b1;
      OES_G0:  oe_sel_val = goe_i[0];
      OES_G1:  oe_sel_val = goe_i[1];
      default: oe_sel_val = oe_pt_i;
    endcase
  end

  assign drv_mode = drives_pad(mode_i);

  generate
    if (1) begin : g_drv
      always_comb begin
        if (od_en_i) begin
          pad_o    = 1'b0;
          pad_oe_o = drv_mode & oe_sel_val & ~dout_i;
        end else begin
          pad_o    = dout_i;
          pad_oe_o = drv_mode & oe_sel_val;
        end
      end
    end
  endgenerate

  // R8
  od_low_only_chk: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    (od_en_i && pad_oe_o) |-> (!pad_o && !dout_i));

  // R6
  goe0_gate_chk: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    (oe_sel_i == OES_G0 && !goe_i[0]) |-> !pad_oe_o);
endmodule

// File: rtl/pio_cell.sv
`timescale 1ns/1ps
module pio_cell
  import pio_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk_io_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic [1:0] oe_sel_i,
  input  logic       od_en_i,
  input  logic       dout_i,
  input  logic       oe_pt_i,
  input  logic       goe0_i,
  input  logic       goe1_i,
  input  logic       pad_i,
  output logic       pad_o,
  output logic       pad_oe_o,
  output logic       din_o
);
  logic [NUM_GOE-1:0] goe;
  assign goe = {goe1_i, goe0_i};

  pio_in_path #(.RST_VAL(RST_VAL)) i_in_path (
    .clk_io_i (clk_io_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .pad_i    (pad_i),
    .dout_i   (dout_i),
    .din_o    (din_o)
  );

  pio_out_drv i_out_drv (
    .clk_io_i (clk_io_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .oe_sel_i (oe_sel_i),
    .od_en_i  (od_en_i),
    .dout_i   (dout_i),
    .oe_pt_i  (oe_pt_i),
    .goe_i    (goe),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );

  // R5
  in_mode_no_drive_chk: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    (mode_i != PIO_OUT && mode_i != PIO_BIDIR) |-> !pad_oe_o);
endmodule

// File: tb/test_pio_cell.sv
`timescale 1ns/1ps
module test_pio_cell;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] mode = 3'd1;
  logic [1:0] sel = 2'd0;
  logic od = 1'b0, dout = 1'b0, pt = 1'b0, g0 = 1'b0, g1 = 1'b0, pad = 1'b1;
  logic pad_o, pad_oe, din;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  po;
    logic  oe;
    logic  din;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pio_cell i_pio_cell (
    .clk_io_i (clk),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .oe_sel_i (sel),
    .od_en_i  (od),
    .dout_i   (dout),
    .oe_pt_i  (pt),
    .goe0_i   (g0),
    .goe1_i   (g1),
    .pad_i    (pad),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe),
    .din_o    (din)
  );

  // inputs change at negedge+2, monitor samples at negedge+5
  task automatic go();
    @(negedge clk);
    #2;
  endtask

  // pad_o rule from R7/R8
  task automatic expect_out(input logic e_oe, input logic e_din, input string tag);
    exp_t it;
    it.po  = od ? 1'b0 : dout;
    it.oe  = e_oe;
    it.din = e_din;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        n_chk++;
        if (pad_o !== it.po || pad_oe !== it.oe || din !== it.din) begin
          n_bad++;
          $display("FAIL %s: got pad_o=%b pad_oe=%b din=%b, exp pad_o=%b pad_oe=%b din=%b",
                   it.tag, pad_o, pad_oe, din, it.po, it.oe, it.din);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    // R1 reset state, flop then latch
    go(); mode = 3'd1; pad = 1'b1; expect_out(1'b0, 1'b0, "R1 flop in reset");
    go(); mode = 3'd2; expect_out(1'b0, 1'b0, "R1 latch in reset");
    // R2 pass-through
    go(); rst_ni = 1'b1; mode = 3'd0; sel = 2'd0; dout = 1'b1; pad = 1'b1;
    expect_out(1'b0, 1'b1, "R2 pass pad=1");
    go(); pad = 1'b0; expect_out(1'b0, 1'b0, "R2 pass pad=0");
    // R5 undefined code, every enable set
    go(); mode = 3'd5; sel = 2'd3; pt = 1'b1; g0 = 1'b1; g1 = 1'b1; pad = 1'b1;
    expect_out(1'b0, 1'b1, "R5 code5 no drive / R2 follows pad");
    // R4 latch: hold in low phase, transparency in high phase
    go(); mode = 3'd2; expect_out(1'b0, 1'b1, "R4 R5 latch no drive");
    go(); pad = 1'b0; expect_out(1'b0, 1'b1, "R4 hold while low");
    go(); pad = 1'b1; expect_out(1'b0, 1'b0, "R4 captured high phase");
    #13 pad = 1'b0;  // change after rising edge, still high
    go(); pad = 1'b1; expect_out(1'b0, 1'b0, "R4 transparent after rise");
    // R3 flop: late change ignored
    go(); mode = 3'd1; expect_out(1'b0, 1'b1, "R3 flop pad=1");
    #13 pad = 1'b0;
    go(); expect_out(1'b0, 1'b1, "R3 late change ignored");
    go(); pad = 1'b1; expect_out(1'b0, 1'b0, "R3 captured 0");
    // R9 drive-only, R6/R7 enable selection
    go(); mode = 3'd3; sel = 2'd0; od = 1'b0; dout = 1'b1; pad = 1'b0; pt = 1'b0; g0 = 1'b0; g1 = 1'b0;
    expect_out(1'b1, 1'b1, "R9 R6 R7 always on, din=dout");
    go(); dout = 1'b0; expect_out(1'b1, 1'b0, "R9 R7 dout=0");
    go(); sel = 2'd1; g1 = 1'b1; expect_out(1'b0, 1'b0, "R6 goe0 low");
    go(); g0 = 1'b1; g1 = 1'b0; expect_out(1'b1, 1'b0, "R6 goe0 high");
    go(); sel = 2'd2; expect_out(1'b0, 1'b0, "R6 goe1 low");
    go(); g1 = 1'b1; g0 = 1'b0; expect_out(1'b1, 1'b0, "R6 goe1 high");
    go(); sel = 2'd3; g1 = 1'b0; g0 = 1'b1; pt = 1'b1; expect_out(1'b1, 1'b0, "R6 pt high");
    go(); pt = 1'b0; g1 = 1'b1; expect_out(1'b0, 1'b0, "R6 pt low");
    // R10 bidirectional
    go(); mode = 3'd4; sel = 2'd0; dout = 1'b1; pad = 1'b0;
    expect_out(1'b1, 1'b0, "R10 din from pad");
    go(); dout = 1'b0; pad = 1'b1; expect_out(1'b1, 1'b1, "R10 pad=1");
    // R8 open-drain
    go(); od = 1'b1; dout = 1'b1; expect_out(1'b0, 1'b1, "R8 od release on 1");
    go(); dout = 1'b0; expect_out(1'b1, 1'b1, "R8 od pull low");
    go(); sel = 2'd1; g0 = 1'b0; expect_out(1'b0, 1'b1, "R8 od gated by goe0");
    go(); mode = 3'd0; sel = 2'd0; expect_out(1'b0, 1'b1, "R5 R8 input mode od");
    // R1 asynchronous reset mid-run
    go(); mode = 3'd1; od = 1'b0; pad = 1'b1; expect_out(1'b0, 1'b1, "R3 flop before reset");
    go(); rst_ni = 1'b0; expect_out(1'b0, 1'b0, "R1 async clear");
    go(); rst_ni = 1'b1;
    go(); expect_out(1'b0, 1'b1, "R3 after reset release");
    go(); go();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule